// File: doc/BRIEF.md
# Fine-Grained Thread Select Unit

This block sits at the issue stage of a single-issue, in-order core that holds four hardware thread contexts. In every clock cycle it names the one thread allowed to issue. It moves to a different thread each cycle whenever another one can go. A thread is passed over while it is blocked. There are two causes of blocking. The first is a short fixed delay that follows a load or a branch issued by that thread. The second is a cache miss that has not yet returned. The issue slot goes unused only when no thread is both valid and unblocked.

The pick is combinational from registered state. The pipeline sees `sel_oh`, `sel_id` and `issue_vld` in the same cycle as the thread's own "has instruction" flag in `thr_vld`. In that same cycle the pipeline reports through `issue_ldbr` whether the issued instruction is a load or a branch. Cache-miss start and return events arrive on per-thread pulse vectors. The rotation pointer and the blocking state update on the rising edge.

Top module: `fine_thread_sel`

## Requirements
- R1: A synchronous active-high `rst` clears every delay countdown and every miss flag, and sets the rotation so that thread 0 is searched first. The first cycle after reset with `thr_vld[0]` high selects thread 0.
- R2: When `issue_vld` is high, exactly one bit of `sel_oh` is set, namely bit t for selected thread t, and `sel_id` equals t in binary. When `issue_vld` is low, `sel_oh` is all zero.
- R3: Only a thread whose `thr_vld` bit is high can be selected.
- R4: The search starts at the thread numbered one above the last thread issued and wraps from 3 to 0. The first thread found that is valid and unblocked wins. In a cycle with no issue the start point does not move.
- R5: An issue with `issue_ldbr` high blocks the issuing thread for the next 3 cycles. The thread can be selected again in the 4th cycle after the issue. Other threads may issue during the gap.
- R6: A high `miss_set[t]` blocks thread t from the next cycle on, until a cycle in which `miss_clr[t]` is high. The thread can be selected again in the cycle after that.
- R7: If `miss_set[t]` and `miss_clr[t]` are high in the same cycle, the new miss wins and thread t is blocked from the next cycle on.
- R8: `issue_vld` is low and `all_idle` is high in exactly the cycles where no thread is both valid and unblocked. In every other cycle one thread issues.
- R9: A thread that has both a pending load/branch delay and an outstanding miss becomes selectable only after both have cleared, whichever clears last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_vld | input | 4 | Per-thread "has an instruction ready to issue" flags |
| issue_ldbr | input | 1 | The instruction issuing this cycle is a load or a branch |
| miss_set | input | 4 | Per-thread cache-miss start pulse |
| miss_clr | input | 4 | Per-thread miss-return pulse |
| sel_oh | output | 4 | One-hot selected thread |
| sel_id | output | 2 | Binary index of the selected thread |
| issue_vld | output | 1 | A thread issues this cycle |
| all_idle | output | 1 | No thread is both valid and unblocked this cycle |

## Verification
Two functions can act on one thread in the same cycle. Miss tracking can see a new miss and a returning miss together. Delay tracking and miss tracking can also be armed by a single issue, one clearing before the other. The bench provokes the first case by pulsing `miss_set` and `miss_clr` for thread 2 in one cycle. It passes the check only if thread 2 stays blocked until a later lone return. It provokes the second case by issuing a load on thread 3 with a miss raised in the same cycle, once with the return arriving early and once late. It expects the first issue from thread 3 only after the later of the two has cleared.

// File: rtl/fts_pkg.sv
package fts_pkg;
  // Wrapping thread index: (base + off) modulo the thread count
  function automatic int wrap_add(input int base, input int off, input int n);
    return (base + off) % n;
  endfunction
endpackage

// File: rtl/fts_thread_ctx.sv
// Per-thread blocking state: load/branch delay countdown plus miss flag
module fts_thread_ctx #(
  parameter int DLY = 3,
  localparam int CW = (DLY < 1) ? 1 : $clog2(DLY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_dly,
  input  logic miss_set,
  input  logic miss_clr,
  output logic ready
);
  logic [CW-1:0] cnt_q;
  logic          miss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      if (load_dly)
        cnt_q <= CW'(DLY);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
      // a new miss outranks a return in the same cycle
      miss_q <= miss_set | (miss_q & ~miss_clr);
    end
  end

  assign ready = (cnt_q == '0) && !miss_q;
endmodule

// File: rtl/fts_rr_pick.sv
// Rotating first-found picker starting at 'start'
module fts_rr_pick #(
  parameter int NTHR = 4,
  localparam int IDW = $clog2(NTHR)
) (
  input  logic [NTHR-1:0] req,
  input  logic [IDW-1:0]  start,
  output logic [NTHR-1:0] gnt_oh,
  output logic [IDW-1:0]  gnt_id,
  output logic            any
);
  always_comb begin
    gnt_oh = '0;
    gnt_id = '0;
    any    = 1'b0;
    for (int off = 0; off < NTHR; off++) begin
      logic [IDW-1:0] idx;
      idx = IDW'(fts_pkg::wrap_add(int'(start), off, NTHR));
      if (!any && req[idx]) begin
        any         = 1'b1;
        gnt_oh[idx] = 1'b1;
        gnt_id      = idx;
      end
    end
  end
endmodule

// File: rtl/fine_thread_sel.sv
module fine_thread_sel #(
  parameter int NTHR = 4,
  parameter int DLY  = 3,
  localparam int IDW = $clog2(NTHR)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NTHR-1:0] thr_vld,
  input  logic            issue_ldbr,
  input  logic [NTHR-1:0] miss_set,
  input  logic [NTHR-1:0] miss_clr,
  output logic [NTHR-1:0] sel_oh,
  output logic [IDW-1:0]  sel_id,
  output logic            issue_vld,
  output logic            all_idle
);
  logic [NTHR-1:0] ready;
  logic [NTHR-1:0] eligible;
  logic [IDW-1:0]  start_q;

  for (genvar g = 0; g < NTHR; g++) begin : g_ctx
    fts_thread_ctx #(.DLY(DLY)) u_ctx (
      .clk      (clk),
      .rst      (rst),
      .load_dly (issue_vld & issue_ldbr & sel_oh[g]),
      .miss_set (miss_set[g]),
      .miss_clr (miss_clr[g]),
      .ready    (ready[g])
    );
  end

  assign eligible = thr_vld & ready;

  fts_rr_pick #(.NTHR(NTHR)) u_pick (
    .req    (eligible),
    .start  (start_q),
    .gnt_oh (sel_oh),
    .gnt_id (sel_id),
    .any    (issue_vld)
  );

  assign all_idle = !issue_vld;

  // rotation: next search begins one past the thread just issued
  always_ff @(posedge clk) begin
    if (rst)
      start_q <= '0;
    else if (issue_vld)
      start_q <= IDW'(fts_pkg::wrap_add(int'(sel_id), 1, NTHR));
  end
endmodule

// File: rtl/fine_thread_sel_chk.sv
module fine_thread_sel_chk #(
  parameter int NTHR = 4,
  parameter int IDW  = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NTHR-1:0] thr_vld,
  input logic            issue_ldbr,
  input logic [NTHR-1:0] miss_set,
  input logic [NTHR-1:0] miss_clr,
  input logic [NTHR-1:0] sel_oh,
  input logic [IDW-1:0]  sel_id,
  input logic            issue_vld,
  input logic            all_idle
);
  // R1
  reset_start_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && thr_vld[0]) |-> sel_oh[0]);

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> ($countones(sel_oh) == 1 && sel_oh[sel_id]));

  // R2
  sel_none_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_vld |-> (sel_oh == '0));

  // R3
  sel_valid_chk: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> ((sel_oh & thr_vld) != '0));

  // R5
  ldbr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && issue_ldbr) |=> ((sel_oh & $past(sel_oh)) == '0));

  // R6
  miss_block_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_set != '0) |=> ((sel_oh & $past(miss_set)) == '0));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_vld == '0) |-> (all_idle && !issue_vld));

  // unused-input sink for lint
  logic unused_ok;
  assign unused_ok = ^miss_clr;
endmodule

bind fine_thread_sel fine_thread_sel_chk #(.NTHR(NTHR), .IDW(IDW)) u_chk (
  .clk(clk), .rst(rst), .thr_vld(thr_vld), .issue_ldbr(issue_ldbr),
  .miss_set(miss_set), .miss_clr(miss_clr), .sel_oh(sel_oh),
  .sel_id(sel_id), .issue_vld(issue_vld), .all_idle(all_idle)
);

// File: tb/fine_thread_sel_test.sv
`timescale 1ns/100ps
module fine_thread_sel_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] thr_vld = '0;
  logic       issue_ldbr = 1'b0;
  logic [3:0] miss_set = '0;
  logic [3:0] miss_clr = '0;
  logic [3:0] sel_oh;
  logic [1:0] sel_id;
  logic       issue_vld;
  logic       all_idle;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fine_thread_sel uut (
    .clk(clk), .rst(rst), .thr_vld(thr_vld), .issue_ldbr(issue_ldbr),
    .miss_set(miss_set), .miss_clr(miss_clr), .sel_oh(sel_oh),
    .sel_id(sel_id), .issue_vld(issue_vld), .all_idle(all_idle)
  );

  // {vld[4], ldbr, mset[4], mclr[4], exp_vld, exp_id[2], req[4]}
  localparam int NV = 41;
  localparam logic [19:0] VEC [NV] = '{
    {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd0, 4'd4},  // R4 rotate
    {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1, 4'd4},
    {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd2, 4'd4},
    {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd3, 4'd4},  // R4 wrap next
    {4'b1010, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1, 4'd4},  // R4 skip invalid
    {4'b1010, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd3, 4'd4},
    {4'b0000, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd8},  // R8 idle
    {4'b0100, 1'b1, 4'b0000, 4'b0000, 1'b1, 2'd2, 4'd5},  // R5 load on t2
    {4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd5},
    {4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd5},
    {4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd5},
    {4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd2, 4'd5},  // R5 4th cycle
    {4'b0011, 1'b1, 4'b0000, 4'b0000, 1'b1, 2'd0, 4'd5},
    {4'b0011, 1'b1, 4'b0000, 4'b0000, 1'b1, 2'd1, 4'd5},  // other fills gap
    {4'b0011, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd5},
    {4'b0011, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd5},
    {4'b0011, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd0, 4'd5},
    {4'b0011, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1, 4'd5},
    {4'b1111, 1'b0, 4'b0100, 4'b0000, 1'b1, 2'd2, 4'd6},  // R6 miss raised
    {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd3, 4'd4},
    {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd0, 4'd4},
    {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1, 4'd4},
    {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd3, 4'd6},  // R6 t2 skipped
    {4'b0100, 1'b0, 4'b0000, 4'b0100, 1'b0, 2'd0, 4'd6},  // return, still blocked
    {4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd2, 4'd6},
    {4'b0100, 1'b0, 4'b0100, 4'b0100, 1'b1, 2'd2, 4'd7},  // R7 set+clr
    {4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd7},
    {4'b0100, 1'b0, 4'b0000, 4'b0100, 1'b0, 2'd0, 4'd7},
    {4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd2, 4'd7},
    {4'b1000, 1'b1, 4'b1000, 4'b0000, 1'b1, 2'd3, 4'd9},  // R9 both armed
    {4'b1000, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd9},
    {4'b1000, 1'b0, 4'b0000, 4'b1000, 1'b0, 2'd0, 4'd9},  // early return
    {4'b1000, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd9},  // delay remains
    {4'b1000, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd3, 4'd9},
    {4'b1000, 1'b1, 4'b1000, 4'b0000, 1'b1, 2'd3, 4'd9},  // R9 again
    {4'b1000, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd9},
    {4'b1000, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd9},
    {4'b1000, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd9},
    {4'b1000, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0, 4'd9},  // miss remains
    {4'b1000, 1'b0, 4'b0000, 4'b1000, 1'b0, 2'd0, 4'd9},  // late return
    {4'b1000, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd3, 4'd9}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // check all outputs against an expected issue/no-issue and thread
  task automatic expect_out(input bit ev, input int eid, input string req);
    logic [3:0] oh;
    oh = ev ? (4'b0001 << eid) : 4'b0000;
    chk(issue_vld == ev, req, int'(issue_vld), int'(ev));
    if (ev) chk(sel_id == 2'(eid), req, int'(sel_id), eid);
    chk(sel_oh == oh, "R2", int'(sel_oh), int'(oh));
    chk(all_idle == !ev, "R8", int'(all_idle), int'(!ev));
    if (issue_vld) chk((sel_oh & thr_vld) != 4'b0000, "R3", int'(sel_oh), int'(thr_vld));
  endtask

  task automatic drive(input logic [3:0] v, input bit lb, input logic [3:0] ms, input logic [3:0] mc);
    @(negedge clk);
    thr_vld = v; issue_ldbr = lb; miss_set = ms; miss_clr = mc;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state: nothing valid means idle
    drive(4'b0000, 1'b0, 4'b0000, 4'b0000);
    expect_out(1'b0, 0, "R1");

    for (int i = 0; i < NV; i++) begin
      logic [19:0] e;
      string tag;
      e = VEC[i];
      tag = $sformatf("R%0d", e[3:0]);
      drive(e[19:16], e[15], e[14:11], e[10:7]);
      expect_out(e[6], int'(e[5:4]), tag);
    end

    // directed: reset mid-run clears delay, miss and rotation (R1)
    drive(4'b1111, 1'b1, 4'b0000, 4'b0000);
    expect_out(1'b1, 0, "R1");
    drive(4'b1111, 1'b0, 4'b0010, 4'b0000);
    expect_out(1'b1, 1, "R1");
    @(negedge clk);
    rst = 1'b1; thr_vld = '0; issue_ldbr = 1'b0; miss_set = '0;
    @(negedge clk);
    rst = 1'b0;
    thr_vld = 4'b1111;
    #1;
    expect_out(1'b1, 0, "R1");
    drive(4'b0010, 1'b0, 4'b0000, 4'b0000);
    expect_out(1'b1, 1, "R1");
    drive(4'b0000, 1'b0, 4'b0000, 4'b0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule